// File: doc/BRIEF.md
# FIFO-Fed Serial Byte Transmitter

This block drains bytes from the read side of an ordinary FIFO and sends each byte as an asynchronous serial frame on one output line. It watches the FIFO's empty flag. Whenever it is free and the flag is low, it raises a one-cycle read strobe. One clock later the FIFO presents the byte (non-first-word-fall-through timing), and the block captures it. The frame goes out as a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits.

The bit period in clock cycles, the parity mode (none, even, odd) and the number of stop bits are fixed when the block is elaborated. For example, a 100 MHz clock at 9600 baud uses 10416 cycles per bit. A frame of 8 data bits therefore lasts 10, 11 or 12 bit periods. If the FIFO still holds data when the last stop bit ends, the next read strobe follows at once. When the FIFO runs dry, the line stays at the idle level and no further reads are issued.

Top module: `fifo_uart_tx`

## Requirements
- R1: While `rst_i` is high at a clock edge, the following cycle shows `tx_o` high and `fifo_rd_en_o` low. After reset, the block is idle.
- R2: While idle with `fifo_empty_i` high, `tx_o` stays high and `fifo_rd_en_o` stays low.
- R3: `fifo_rd_en_o` is a pulse exactly one cycle wide. It is raised only at a clock edge where `fifo_empty_i` was sampled low, and only from idle or at the end of the final stop bit.
- R4: The byte on `fifo_data_i` is captured at the second clock edge after the edge that raised `fifo_rd_en_o`. The start bit begins at that same edge.
- R5: The start bit drives `tx_o` low for exactly `CLKS_PER_BIT` cycles.
- R6: The `DATA_W` data bits follow the start bit with bit 0 first. Each bit is held for `CLKS_PER_BIT` cycles, and `tx_o` changes only at bit boundaries.
- R7: With `PARITY_MODE` set to PAR_EVEN (encoding 1), one parity bit follows the data. It makes the number of ones across the data and parity even. With PAR_ODD (encoding 2), that number is odd. With PAR_NONE (encoding 0), no parity bit is sent.
- R8: Every frame ends with `STOP_BITS` (1 or 2) high bit periods.
- R9: If `fifo_empty_i` is low at the edge that ends the last stop bit, `fifo_rd_en_o` is high in the very next cycle. The next start bit then begins two cycles later, with `tx_o` high in between.
- R10: If `fifo_empty_i` is high when a frame ends, no read is issued and `tx_o` remains high until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_data_i | input | DATA_W | FIFO read data, valid the cycle after a read strobe |
| fifo_rd_en_o | output | 1 | One-cycle FIFO read strobe |
| tx_o | output | 1 | Serial output line, high when idle |

## Verification
Each of three bench lanes builds the transmitter with a different mix of parity mode, stop-bit count and bit period, including the one-cycle bit period. Every lane uses the byte patterns all-zero, all-one, alternating and single-bit-set. These patterns separate a reversed bit order from a correct one, an even parity bit from an odd one, and a stuck line from real data.

Bytes are queued in several ways, and each one isolates a different transition:
- A burst queued all at once exercises the direct stop-to-read handoff.
- A lone byte after a long empty spell exercises the return to idle.
- A reset that lands in the middle of a frame shows the line snapping back to idle while the FIFO keeps its remaining bytes.

// File: rtl/fifo_uart_tx_pkg.sv
package fifo_uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_CAPT  = 3'd2,
    ST_START = 3'd3,
    ST_DATA  = 3'd4,
    ST_PAR   = 3'd5,
    ST_STOP  = 3'd6
  } tx_state_e;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int CLKS_PER_BIT = 10416
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  // tick marks the last cycle of the current bit period
  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import fifo_uart_tx_pkg::*;
#(
  parameter int      DATA_W = 8,
  parameter parity_e MODE   = PAR_NONE
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              par_o
);
  generate
    if (MODE == PAR_EVEN) begin : g_even
      assign par_o = ^data_i;
    end else if (MODE == PAR_ODD) begin : g_odd
      assign par_o = ~^data_i;
    end else begin : g_none
      assign par_o = 1'b0 & (^data_i);
    end
  endgenerate
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              lsb_o
);
  logic [DATA_W-1:0] sh_q;

  assign lsb_o = sh_q[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= data_i;
    end else if (shift_i) begin
      sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/uart_tx_frame_fsm.sv
module uart_tx_frame_fsm
  import fifo_uart_tx_pkg::*;
#(
  parameter int      DATA_W      = 8,
  parameter parity_e PARITY_MODE = PAR_NONE,
  parameter int      STOP_BITS   = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic empty_i,
  input  logic tick_i,
  input  logic lsb_i,
  input  logic par_i,
  output logic rd_en_o,
  output logic tx_o,
  output logic timer_clr_o,
  output logic load_o,
  output logic shift_o
);
  localparam bit HAS_PAR = (PARITY_MODE != PAR_NONE);
  localparam int IW      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);
  localparam logic LAST_STOP = (STOP_BITS > 1) ? 1'b1 : 1'b0;

  tx_state_e     state_q;
  logic [IW-1:0] bit_idx_q;
  logic          stop_idx_q;
  logic          par_q;
  logic          tx_q;
  logic          rd_q;

  assign tx_o        = tx_q;
  assign rd_en_o     = rd_q;
  assign load_o      = (state_q == ST_CAPT);
  assign shift_o     = tick_i && ((state_q == ST_START) ||
                       ((state_q == ST_DATA) && (bit_idx_q != LAST_BIT)));
  assign timer_clr_o = (state_q == ST_IDLE) || (state_q == ST_REQ) ||
                       (state_q == ST_CAPT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_IDLE;
      bit_idx_q  <= '0;
      stop_idx_q <= 1'b0;
      par_q      <= 1'b0;
      tx_q       <= 1'b1;
      rd_q       <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (!empty_i) begin
            rd_q    <= 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          state_q <= ST_CAPT;
        end
        ST_CAPT: begin
          par_q   <= par_i;
          tx_q    <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: begin
          if (tick_i) begin
            tx_q      <= lsb_i;
            bit_idx_q <= '0;
            state_q   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (bit_idx_q == LAST_BIT) begin
              if (HAS_PAR) begin
                tx_q    <= par_q;
                state_q <= ST_PAR;
              end else begin
                tx_q       <= 1'b1;
                stop_idx_q <= 1'b0;
                state_q    <= ST_STOP;
              end
            end else begin
              tx_q      <= lsb_i;
              bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            tx_q       <= 1'b1;
            stop_idx_q <= 1'b0;
            state_q    <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (stop_idx_q == LAST_STOP) begin
              if (!empty_i) begin
                rd_q    <= 1'b1;
                state_q <= ST_REQ;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              stop_idx_q <= 1'b1;
            end
          end
        end
        default: begin
          tx_q    <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx
  import fifo_uart_tx_pkg::*;
#(
  parameter int      CLKS_PER_BIT = 10416,
  parameter int      DATA_W       = 8,
  parameter parity_e PARITY_MODE  = PAR_NONE,
  parameter int      STOP_BITS    = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_en_o,
  output logic              tx_o
);
  logic bit_tick;
  logic timer_clr;
  logic load;
  logic shift;
  logic lsb;
  logic par_bit;

  uart_tx_bit_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clear_i(timer_clr),
    .tick_o (bit_tick)
  );

  uart_tx_parity #(
    .DATA_W(DATA_W),
    .MODE  (PARITY_MODE)
  ) u_parity (
    .data_i(fifo_data_i),
    .par_o (par_bit)
  );

  uart_tx_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .shift_i(shift),
    .data_i (fifo_data_i),
    .lsb_o  (lsb)
  );

  uart_tx_frame_fsm #(
    .DATA_W     (DATA_W),
    .PARITY_MODE(PARITY_MODE),
    .STOP_BITS  (STOP_BITS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .empty_i    (fifo_empty_i),
    .tick_i     (bit_tick),
    .lsb_i      (lsb),
    .par_i      (par_bit),
    .rd_en_o    (fifo_rd_en_o),
    .tx_o       (tx_o),
    .timer_clr_o(timer_clr),
    .load_o     (load),
    .shift_o    (shift)
  );
endmodule

// File: rtl/fifo_uart_tx_chk.sv
module fifo_uart_tx_chk (
  input logic clk_i,
  input logic rst_i,
  input logic fifo_empty_i,
  input logic fifo_rd_en_o,
  input logic tx_o,
  input logic bit_tick
);
  // R3
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_en_o |=> !fifo_rd_en_o);

  // R3
  rd_needs_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_en_o |-> !$past(fifo_empty_i));

  // R4
  start_after_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(fifo_rd_en_o, 2) && !$past(rst_i) && !$past(rst_i, 2)) |-> !tx_o);

  // R9
  rd_line_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_en_o |-> tx_o);

  // R6
  tx_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(tx_o) |-> ($past(bit_tick) || $past(fifo_rd_en_o, 2) || $past(rst_i)));
endmodule

bind fifo_uart_tx fifo_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_rd_en_o(fifo_rd_en_o),
  .tx_o        (tx_o),
  .bit_tick    (bit_tick)
);

// File: tb/tb_fifo_uart_tx.sv
module tb_uart_lane
  import fifo_uart_tx_pkg::*;
#(
  parameter int      CLKS  = 4,
  parameter parity_e PAR   = PAR_NONE,
  parameter int      STOPS = 1,
  parameter bit      MIDRST = 1'b0
) (
  input logic clk
);
  logic       rst;
  logic       empty;
  logic [7:0] dout;
  logic       rd_en;
  logic       tx;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  bit   m_idle;

  logic [7:0] src [0:15];
  int   avail  = 0;
  int   rd_idx = 0;

  bit    wave_b [$];
  string wave_t [$];

  fifo_uart_tx #(
    .CLKS_PER_BIT(CLKS),
    .DATA_W      (8),
    .PARITY_MODE (PAR),
    .STOP_BITS   (STOPS)
  ) dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .fifo_empty_i(empty),
    .fifo_data_i (dout),
    .fifo_rd_en_o(rd_en),
    .tx_o        (tx)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s lane(clks=%0d par=%0d stops=%0d) t=%0t actual=%b expected=%b",
               tag, what, CLKS, PAR, STOPS, $time, act, exp);
    end
  endtask

  task automatic push_bits(input bit b, input string tag);
    for (int i = 0; i < CLKS; i++) begin
      wave_b.push_back(b);
      wave_t.push_back(tag);
    end
  endtask

  // behavioural reference, sampled between clock edges
  initial begin
    bit    fstep;
    bit    prev_busy;
    bit    et, er;
    string tg;
    fstep = 0; prev_busy = 0;
    empty = 1'b1;
    dout  = 8'h00;
    forever begin
      @(negedge clk);
      if (rst) begin
        wave_b.delete(); wave_t.delete();
        fstep = 0; prev_busy = 0;
        et = 1; er = 0; tg = "R1";
      end else if (fstep) begin
        et = 1; er = 0; tg = "R4";
        fstep = 0;
        push_bits(1'b0, "R5");
        for (int i = 0; i < 8; i++) push_bits(dout[i], "R6");
        if (PAR == PAR_EVEN) push_bits(^dout, "R7");
        if (PAR == PAR_ODD)  push_bits(~^dout, "R7");
        for (int s = 0; s < STOPS; s++) push_bits(1'b1, "R8");
        prev_busy = 1;
      end else if (wave_b.size() > 0) begin
        et = wave_b.pop_front();
        tg = wave_t.pop_front();
        er = 0;
        prev_busy = 1;
      end else if (!empty) begin
        et = 1; er = 1; fstep = 1;
        tg = prev_busy ? "R9" : "R3";
        prev_busy = 0;
      end else begin
        et = 1; er = 0;
        tg = prev_busy ? "R10" : "R2";
        prev_busy = 0;
      end
      m_idle = !fstep && (wave_b.size() == 0) && !er;
      check(tg, "tx", tx, et);
      check(tg, "rd_en", rd_en, er);
      if (rd_en === 1'b1) begin
        if (rd_idx < avail) dout = src[rd_idx];
        rd_idx++;
      end
      empty = (rd_idx >= avail);
    end
  end

  task automatic wait_drained();
    do @(negedge clk); while (!(m_idle && (rd_idx >= avail)));
    repeat (6) @(negedge clk);
  endtask

  initial begin
    src[0] = 8'h00; src[1] = 8'hFF; src[2] = 8'h55; src[3] = 8'hA5;
    src[4] = 8'h01; src[5] = 8'h80; src[6] = 8'h3C; src[7] = 8'hC3;
    src[8] = 8'h7E; src[9] = 8'h81;
    for (int i = 10; i < 16; i++) src[i] = 8'(i * 37);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R2: idle with nothing queued
    repeat (8) @(negedge clk);
    // R9: burst of four bytes
    #1 avail = 4;
    wait_drained();
    // R10: lone byte after an empty spell
    #1 avail = 5;
    wait_drained();
    if (MIDRST) begin
      // R1: reset lands inside a frame
      #1 avail = 7;
      repeat (CLKS * 4 + 5) @(negedge clk);
      #1 rst = 1'b1;
      repeat (2) @(negedge clk);
      #1 rst = 1'b0;
      wait_drained();
    end else begin
      #1 avail = 7;
      wait_drained();
    end
    #1 avail = 10;
    wait_drained();
    done = 1'b1;
  end
endmodule

module tb_fifo_uart_tx;
  import fifo_uart_tx_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  tb_uart_lane #(.CLKS(4), .PAR(PAR_NONE), .STOPS(1), .MIDRST(1'b0)) lane0 (.clk(clk));
  tb_uart_lane #(.CLKS(3), .PAR(PAR_EVEN), .STOPS(2), .MIDRST(1'b1)) lane1 (.clk(clk));
  tb_uart_lane #(.CLKS(1), .PAR(PAR_ODD),  .STOPS(1), .MIDRST(1'b0)) lane2 (.clk(clk));

  initial begin
    int cyc;
    int tot_chk;
    int tot_fail;
    cyc = 0;
    while (!(lane0.done && lane1.done && lane2.done) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    tot_chk  = lane0.n_chk + lane1.n_chk + lane2.n_chk;
    tot_fail = lane0.n_fail + lane1.n_fail + lane2.n_fail;
    if (!(lane0.done && lane1.done && lane2.done)) begin
      tot_chk++;
      tot_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", tot_chk, tot_fail);
    $finish;
  end
endmodule